// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit side of a synchronous serial port that runs as a slave. An external master supplies the shift clock on `ext_sck`. The block brings that clock into the system clock domain, finds its falling edges and uses them to move data out on `tx_out`, least significant bit first. The master samples each bit on the following rising edge.

Software writes words into a holding register. When the shift register is idle, a written word goes straight into it and starts shifting. A word written while another is shifting waits in the holding register and moves across when the last bit of the current word has been sent. An optional ninth bit is taken from a separate control input at the moment of the write and is sent last. The block decodes the port's mode bits: port enable, synchronous mode, clock source, transmit enable and the two receive enables. It shifts only in slave-transmit mode. It reports a buffer-empty flag, a shift-empty status bit and a gated interrupt request.

Top module: `sync_slave_tx`

## Requirements
- R1: Words move into the shift register and bits advance only while cfg_port_en=1, cfg_tx_en=1, cfg_sync_mode=1, cfg_clk_master=0, cfg_rx_single=0 and cfg_rx_cont=0. With the port and transmit enables set but cfg_clk_master=1, a written word stays pending.
- R2: While either receive enable is 1 (port and transmit enables still set), nothing shifts and tx_out stays 1. A written word stays in the holding register. One system cycle after both receive enables clear, it moves into the shift register.
- R3: A write (wr_hold=1 for one cycle) in slave-transmit mode with the shift register empty loads the word at that clock edge. After that edge, shift_empty=0, hold_empty=1 and tx_out shows bit 0 of the word.
- R4: A word written while another word is shifting makes hold_empty 0. hold_empty stays 0 until the shifting word has sent its last bit.
- R5: On the synchronized falling ext_sck edge that ends the last bit, a pending word moves into the shift register. At that moment hold_empty becomes 1, shift_empty stays 0 and tx_out shows the new word's bit 0.
- R6: In 8-bit mode the word is sent least significant bit first. Each synchronized falling edge of ext_sck advances one bit, and 8 falling edges complete the word.
- R7: If cfg_nine_bit=1 at the write, cfg_bit8 is captured as bit 8 and sent after the low 8 bits, and the word takes 9 falling edges.
- R8: irq is 1 exactly when hold_empty=1, cfg_irq_en=1 and cfg_periph_irq_en=1.
- R9: After reset and whenever no word is shifting, shift_empty=1 and tx_out=1. After reset, hold_empty=1.
- R10: Clearing cfg_port_en or cfg_tx_en aborts any shift and discards the pending word. One cycle later, hold_empty=1, shift_empty=1 and tx_out=1.
- R11: A write while the holding register is full replaces the pending word and leaves the word currently shifting unchanged.
- R12: A write while cfg_port_en=0 or cfg_tx_en=0 is ignored: hold_empty and shift_empty both stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_sync_mode | input | 1 | 1 selects synchronous operation |
| cfg_clk_master | input | 1 | 1 selects internal clock source (master); 0 is slave |
| cfg_rx_single | input | 1 | Single-word receive enable |
| cfg_rx_cont | input | 1 | Continuous receive enable |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_nine_bit | input | 1 | 1 selects 9-bit words, sampled at the write |
| cfg_bit8 | input | 1 | Ninth data bit, sampled at the write |
| cfg_irq_en | input | 1 | Transmit interrupt enable |
| cfg_periph_irq_en | input | 1 | Peripheral interrupt enable |
| wr_hold | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Low data bits to write |
| ext_sck | input | 1 | Shift clock from the external master, asynchronous |
| tx_out | output | 1 | Serial data out, idle high |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Gated transmit interrupt request |

## Verification
The assertions assume that wr_hold is a single-cycle strobe sampled on the system clock. They also assume that ext_sck stays at each level for more system cycles than the synchronizer depth, so that each falling edge appears as exactly one detect pulse. The stimulus changes inputs only on the falling system clock edge. It holds every ext_sck phase for six system cycles, and it changes mode bits only between ext_sck edges. Because the external clock is never faster than the synchronizer can follow, no falling edge of it is missed or counted twice.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

    // Operating state decoded from the control bits
    typedef enum logic [1:0] {
        SSTX_OFF   = 2'd0,  // port or transmitter disabled: registers cleared
        SSTX_PAUSE = 2'd1,  // enabled but not in slave-transmit mode: frozen
        SSTX_RUN   = 2'd2   // slave-transmit mode: load and shift
    } sstx_mode_e;

endpackage

// File: rtl/sstx_clk_sync.sv
module sstx_clk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic fall_o
);
    localparam int unsigned PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[PIPE_W-2:0], sck_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{pipe: '1};
        else        sync_q <= sync_d;
    end

    // older sample high, newer sample low: a falling edge
    assign fall_o = sync_q.pipe[PIPE_W-1] & ~sync_q.pipe[PIPE_W-2];

endmodule

// File: rtl/sstx_mode_dec.sv
module sstx_mode_dec
    import sstx_pkg::*;
(
    input  logic       port_en_i,
    input  logic       sync_mode_i,
    input  logic       clk_master_i,
    input  logic       rx_single_i,
    input  logic       rx_cont_i,
    input  logic       tx_en_i,
    output sstx_mode_e mode_o
);
    always_comb begin
        if (!port_en_i || !tx_en_i)
            mode_o = SSTX_OFF;
        else if (sync_mode_i && !clk_master_i && !rx_single_i && !rx_cont_i)
            mode_o = SSTX_RUN;
        else
            mode_o = SSTX_PAUSE;
    end
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
    import sstx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sstx_mode_e        mode_i,
    input  logic              fall_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              nine_i,
    input  logic              bit8_i,
    output logic              tx_o,
    output logic              hold_empty_o,
    output logic              shift_empty_o
);
    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

    typedef struct packed {
        logic [WORD_W-1:0] hold_data;
        logic              hold_nine;
        logic              hold_full;
        logic [WORD_W-1:0] sh_data;
        logic [CNT_W-1:0]  sh_cnt;
        logic [CNT_W-1:0]  sh_last;
        logic              sh_busy;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_i == SSTX_OFF) begin
            st_d = '0;
        end else begin
            // advance or finish the word in flight
            if (mode_i == SSTX_RUN && st_q.sh_busy && fall_i) begin
                if (st_q.sh_cnt == st_q.sh_last) begin
                    st_d.sh_busy = 1'b0;
                end else begin
                    st_d.sh_data = {1'b0, st_q.sh_data[WORD_W-1:1]};
                    st_d.sh_cnt  = st_q.sh_cnt + 1'b1;
                end
            end
            // a write fills or overwrites the holding register
            if (wr_i) begin
                st_d.hold_data = {bit8_i & nine_i, wr_data_i};
                st_d.hold_nine = nine_i;
                st_d.hold_full = 1'b1;
            end
            // move a pending word into an idle shift register
            if (mode_i == SSTX_RUN && !st_d.sh_busy && st_d.hold_full) begin
                st_d.sh_data   = st_d.hold_data;
                st_d.sh_last   = st_d.hold_nine ? LAST9 : LAST8;
                st_d.sh_cnt    = '0;
                st_d.sh_busy   = 1'b1;
                st_d.hold_full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_o          = st_q.sh_busy ? st_q.sh_data[0] : 1'b1;
    assign hold_empty_o  = ~st_q.hold_full;
    assign shift_empty_o = ~st_q.sh_busy;

    // R10: a disable clears both registers
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SSTX_OFF) |=> (hold_empty_o && shift_empty_o && tx_o));

    // R3: a write into an idle shift register loads it at once
    p_immediate_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SSTX_RUN && wr_i && shift_empty_o) |=> (!shift_empty_o && hold_empty_o));

    // R4 / R11: a write during a shift leaves a pending word
    p_write_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SSTX_OFF && wr_i && !shift_empty_o && !fall_i) |=> !hold_empty_o);

    // R2: outside slave-transmit mode the serial output is frozen
    p_pause_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SSTX_PAUSE) |=> $stable(tx_o) && $stable(shift_empty_o));

    // R9: idle line is high
    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty_o |-> tx_o);

    // R6: a non-final falling edge presents the next bit
    p_lsb_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SSTX_RUN && st_q.sh_busy && fall_i && st_q.sh_cnt != st_q.sh_last)
        |=> (tx_o == $past(st_q.sh_data[1])));

endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import sstx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_port_en,
    input  logic              cfg_sync_mode,
    input  logic              cfg_clk_master,
    input  logic              cfg_rx_single,
    input  logic              cfg_rx_cont,
    input  logic              cfg_tx_en,
    input  logic              cfg_nine_bit,
    input  logic              cfg_bit8,
    input  logic              cfg_irq_en,
    input  logic              cfg_periph_irq_en,
    input  logic              wr_hold,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_sck,
    output logic              tx_out,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              irq
);
    sstx_mode_e mode;
    logic       sck_fall;

    sstx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (ext_sck),
        .fall_o (sck_fall)
    );

    sstx_mode_dec u_mode (
        .port_en_i    (cfg_port_en),
        .sync_mode_i  (cfg_sync_mode),
        .clk_master_i (cfg_clk_master),
        .rx_single_i  (cfg_rx_single),
        .rx_cont_i    (cfg_rx_cont),
        .tx_en_i      (cfg_tx_en),
        .mode_o       (mode)
    );

    sstx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .fall_i        (sck_fall),
        .wr_i          (wr_hold),
        .wr_data_i     (wr_data),
        .nine_i        (cfg_nine_bit),
        .bit8_i        (cfg_bit8),
        .tx_o          (tx_out),
        .hold_empty_o  (hold_empty),
        .shift_empty_o (shift_empty)
    );

    assign irq = hold_empty & cfg_irq_en & cfg_periph_irq_en;

    // R8: a pending word always keeps the request low
    p_irq_needs_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty) |-> !irq);

endmodule

// File: tb/tb_sync_slave_tx.sv
module tb_sync_slave_tx;
    localparam int unsigned DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_port_en = 1'b1, cfg_sync_mode = 1'b1, cfg_clk_master = 1'b0;
    logic cfg_rx_single = 1'b0, cfg_rx_cont = 1'b0, cfg_tx_en = 1'b1;
    logic cfg_nine_bit = 1'b0, cfg_bit8 = 1'b0;
    logic cfg_irq_en = 1'b0, cfg_periph_irq_en = 1'b0;
    logic wr_hold = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic ext_sck = 1'b1;
    logic tx_out, hold_empty, shift_empty, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sync_slave_tx #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_port_en(cfg_port_en), .cfg_sync_mode(cfg_sync_mode),
        .cfg_clk_master(cfg_clk_master), .cfg_rx_single(cfg_rx_single),
        .cfg_rx_cont(cfg_rx_cont), .cfg_tx_en(cfg_tx_en),
        .cfg_nine_bit(cfg_nine_bit), .cfg_bit8(cfg_bit8),
        .cfg_irq_en(cfg_irq_en), .cfg_periph_irq_en(cfg_periph_irq_en),
        .wr_hold(wr_hold), .wr_data(wr_data), .ext_sck(ext_sck),
        .tx_out(tx_out), .hold_empty(hold_empty), .shift_empty(shift_empty),
        .irq(irq)
    );

    // {nine-bit mode, ninth bit, data}
    localparam logic [9:0] VEC [0:7] = '{
        10'h0A5, 10'h001, 10'h080, 10'h0FF,
        10'h35A, 10'h200, 10'h3FF, 10'h23C
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d, input logic b8);
        @(negedge clk);
        wr_hold = 1'b1; wr_data = d; cfg_bit8 = b8;
        @(negedge clk);
        wr_hold = 1'b0;
    endtask

    task automatic sck_fall();
        ext_sck = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic sck_rise();
        ext_sck = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // sample each bit while sck is high, then fall and rise
    task automatic shift_bits(input int n, output logic [8:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got[i] = tx_out;
            sck_fall();
            sck_rise();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [8:0] got;
        logic [8:0] exp;
        int nb;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R9 reset tx_out", tx_out, 1);
        check("R9 reset hold_empty", hold_empty, 1);
        check("R9 reset shift_empty", shift_empty, 1);
        check("R8 reset irq off", irq, 0);

        // vector table: one word each, 8- or 9-bit (R6, R7)
        foreach (VEC[k]) begin
            cfg_nine_bit = VEC[k][9];
            nb  = VEC[k][9] ? 9 : 8;
            exp = VEC[k][9] ? {VEC[k][8], VEC[k][7:0]} : {1'b0, VEC[k][7:0]};
            write(VEC[k][7:0], VEC[k][8]);
            check("R3 load shift_empty", shift_empty, 0);
            check("R3 load hold_empty", hold_empty, 1);
            shift_bits(nb, got);
            check(VEC[k][9] ? "R7 nine-bit word" : "R6 eight-bit word", got, exp);
            check("R9 idle after word", {shift_empty, tx_out}, 2'b11);
        end
        cfg_nine_bit = 1'b0;

        // double buffering (R3, R4, R5)
        write(8'h96, 1'b0);
        check("R3 tx_out shows bit0", tx_out, 0);
        write(8'h3B, 1'b0);
        check("R4 pending word hold_empty", hold_empty, 0);
        shift_bits(7, got);
        check("R4 still pending after 7 bits", hold_empty, 0);
        check("R6 first 7 bits", got[6:0], 7'h16);
        check("R6 eighth bit", tx_out, 1);
        sck_fall();
        check("R5 transfer hold_empty", hold_empty, 1);
        check("R5 transfer shift_empty", shift_empty, 0);
        check("R5 next bit0", tx_out, 1);
        sck_rise();
        shift_bits(8, got);
        check("R5 second word", got[7:0], 8'h3B);

        // overwrite (R11)
        write(8'h11, 1'b0);
        write(8'h22, 1'b0);
        write(8'hC4, 1'b0);
        shift_bits(8, got);
        check("R11 shifting word untouched", got[7:0], 8'h11);
        shift_bits(8, got);
        check("R11 pending replaced", got[7:0], 8'hC4);
        check("R11 idle after", shift_empty, 1);

        // receive enable blocks shifting (R2)
        cfg_rx_cont = 1'b1;
        write(8'h6E, 1'b0);
        check("R2 word pending", hold_empty, 0);
        check("R2 no load", shift_empty, 1);
        sck_fall();
        check("R2 tx_out high", tx_out, 1);
        sck_rise();
        cfg_rx_cont = 1'b0;
        @(negedge clk);
        check("R2 load after rx clear", {shift_empty, hold_empty}, 2'b01);
        shift_bits(8, got);
        check("R2 word delivered", got[7:0], 8'h6E);

        // master clock source blocks shifting (R1)
        cfg_clk_master = 1'b1;
        write(8'hA1, 1'b0);
        check("R1 master holds word", {shift_empty, hold_empty}, 2'b10);
        cfg_clk_master = 1'b0;
        @(negedge clk);
        check("R1 slave releases word", {shift_empty, hold_empty}, 2'b01);
        shift_bits(8, got);
        check("R1 word delivered", got[7:0], 8'hA1);

        // abort (R10)
        write(8'h0F, 1'b0);
        write(8'hF0, 1'b0);
        sck_fall();
        cfg_tx_en = 1'b0;
        @(negedge clk);
        check("R10 abort flags", {hold_empty, shift_empty, tx_out}, 3'b111);
        sck_rise();

        // writes ignored when disabled (R12)
        write(8'h55, 1'b0);
        check("R12 tx disabled write ignored", {hold_empty, shift_empty}, 2'b11);
        cfg_tx_en = 1'b1;
        cfg_port_en = 1'b0;
        write(8'h55, 1'b0);
        check("R12 port disabled write ignored", {hold_empty, shift_empty}, 2'b11);
        cfg_port_en = 1'b1;
        @(negedge clk);
        check("R12 nothing loaded on enable", shift_empty, 1);

        // interrupt gating (R8)
        cfg_irq_en = 1'b1;
        @(negedge clk);
        check("R8 only tx enable", irq, 0);
        cfg_periph_irq_en = 1'b1;
        @(negedge clk);
        check("R8 both enables", irq, 1);
        cfg_irq_en = 1'b0;
        @(negedge clk);
        check("R8 only peripheral enable", irq, 0);
        cfg_irq_en = 1'b1;
        write(8'h81, 1'b0);
        write(8'h7E, 1'b0);
        check("R8 pending word blocks irq", irq, 0);
        shift_bits(8, got);
        check("R8 irq after transfer", irq, 1);
        shift_bits(8, got);
        check("R8 second word", got[7:0], 8'h7E);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule